// File: doc/BRIEF.md
# I2C Command and Data Queue Front End

This block sits between a register bus and the bit-level engine of an I2C master. Software writes 9-bit command words into a transmit queue through one shared command/data register. A word with bit 8 clear carries a byte to transmit. A word with bit 8 set asks the engine to read one byte. Reading the same register pops the oldest byte that the engine has delivered into the receive queue.

The engine drains the transmit queue with a valid/ready handshake. It returns each received byte with a one-cycle strobe. Software paces the transfer with two programmable thresholds:
- a transmit-low event, raised while few commands remain queued;
- a receive-high event, raised while enough bytes are waiting.

Misuse raises sticky error flags: writing into a full transmit queue, reading from an empty receive queue, or delivering a byte to a full receive queue. An abort from the engine discards everything held in both queues.

Top module: `i2c_xfer_queue`

## Requirements
- R1: A write of a word with bit 8 = 0 to address 0 enqueues it; the engine later sees `txCmd` = {1'b0, low byte}.
- R2: A write of a word with bit 8 = 1 to address 0 enqueues a read request; its low 8 bits are discarded, so the engine sees `txCmd` = 9'h100.
- R3: A read of address 0 returns the oldest received byte and removes it; bytes come out in arrival order.
- R4: Address 1 reads the number of queued commands and address 2 the number of queued received bytes; both are 0 after reset.
- R5: `txEmptyEvt` (also bit 3 of address 5) is 1 exactly while the transmit count is less than or equal to the transmit threshold at address 3 (reset value 0).
- R6: `rxFullEvt` (also bit 4 of address 5) is 1 exactly while the receive count is greater than the receive threshold at address 4 (reset value 0).
- R7: A cycle with `abortReq` = 1 empties both queues; both counts read 0 afterwards and `txValid` is 0.
- R8: A command write while the transmit queue holds its full depth (8 by default) is dropped without altering the queue, and sets bit 0 of address 5.
- R9: A read of address 0 while the receive queue is empty returns 0, leaves the count at 0, and sets bit 1 of address 5.
- R10: A received-byte strobe while the receive queue is full drops the byte and sets bit 2 of address 5.
- R11: `txValid` is 1 while the transmit queue is not empty, and an entry is removed in each cycle where `txValid` and `txReady` are both 1.
- R12: Writing 1 to bits 0, 1 or 2 of address 5 clears the matching error flag; writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive queue at address 0) |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational from `regAddr` |
| txValid | output | 1 | Transmit queue has a command for the engine |
| txReady | input | 1 | Engine accepts the head command |
| txCmd | output | 9 | Head command word |
| rxStrobe | input | 1 | Engine delivers one received byte |
| rxByte | input | 8 | Received byte |
| abortReq | input | 1 | Transfer aborted: discard both queues |
| txEmptyEvt | output | 1 | Transmit count at or below threshold |
| rxFullEvt | output | 1 | Receive count above threshold |

## Verification
The embedded assertions check four properties on every cycle:
- no queue is pushed while full or popped while empty;
- an abort leaves both counts at zero one cycle later;
- each misuse condition raises its sticky flag one cycle later;
- the threshold events agree with the empty states.

Other properties only the directed scenarios can show:
- command order and content at the engine side, including the zeroing of read-request low bits;
- byte order on readout;
- that a dropped write leaves the queued entries unchanged;
- the exact boundary where each threshold event switches;
- write-one-to-clear behaviour of the flags.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int REG_DATA_W = 16;
  localparam int CMD_W      = 9;
  localparam int BYTE_W     = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_CMD   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_TXLVL = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_RXLVL = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_TXTHR = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_RXTHR = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_EVT   = 3'd5;

  // event register bit positions
  localparam int EVT_TXOVER  = 0;
  localparam int EVT_RXUNDER = 1;
  localparam int EVT_RXOVER  = 2;
  localparam int EVT_TXLOW   = 3;
  localparam int EVT_RXHIGH  = 4;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } qStrobes_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         flush,
  input  logic [WIDTH-1:0]             din,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign dout  = mem[rdPtr];
  assign level = count;
  assign full  = (count == LVL_W'(DEPTH));
  assign empty = (count == '0);

  AST_PUSH_NOT_FULL:  assert property (@(posedge clk) disable iff (!rstN) push |-> !full);            // R8 R10
  AST_POP_NOT_EMPTY:  assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty);            // R9 R11
  AST_FLUSH_CLEARS:   assert property (@(posedge clk) disable iff (!rstN) flush |=> (level == '0));   // R7
  AST_LEVEL_BOUND:    assert property (@(posedge clk) disable iff (!rstN) level <= LVL_W'(DEPTH));    // R4
endmodule

// File: rtl/i2cq_datapath.sv
module i2cq_datapath
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  qStrobes_t                       stb,
  input  logic [CMD_W-1:0]                cmdWord,
  input  logic [BYTE_W-1:0]               rxDin,
  output logic [CMD_W-1:0]                txHead,
  output logic [BYTE_W-1:0]               rxHead,
  output logic [$clog2(TX_DEPTH+1)-1:0]   txLevel,
  output logic [$clog2(RX_DEPTH+1)-1:0]   rxLevel,
  output logic                            txIsFull,
  output logic                            txIsEmpty,
  output logic                            rxIsFull,
  output logic                            rxIsEmpty
);
  // a read request carries no payload: store it with a clean low byte
  logic [CMD_W-1:0] txDin;
  assign txDin = cmdWord[CMD_W-1] ? {1'b1, {BYTE_W{1'b0}}} : cmdWord;

  i2cq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) txQ (
    .clk(clk), .rstN(rstN),
    .push(stb.txPush), .pop(stb.txPop), .flush(stb.flush),
    .din(txDin), .dout(txHead), .level(txLevel),
    .full(txIsFull), .empty(txIsEmpty)
  );

  i2cq_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) rxQ (
    .clk(clk), .rstN(rstN),
    .push(stb.rxPush), .pop(stb.rxPop), .flush(stb.flush),
    .din(rxDin), .dout(rxHead), .level(rxLevel),
    .full(rxIsFull), .empty(rxIsEmpty)
  );
endmodule

// File: rtl/i2cq_control.sv
module i2cq_control
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic                            regRdEn,
  input  logic [REG_ADDR_W-1:0]           regAddr,
  input  logic [REG_DATA_W-1:0]           regWrData,
  output logic [REG_DATA_W-1:0]           regRdData,
  input  logic                            txReady,
  input  logic                            rxStrobe,
  input  logic                            abortReq,
  input  logic [$clog2(TX_DEPTH+1)-1:0]   txLevel,
  input  logic [$clog2(RX_DEPTH+1)-1:0]   rxLevel,
  input  logic                            txIsFull,
  input  logic                            txIsEmpty,
  input  logic                            rxIsFull,
  input  logic                            rxIsEmpty,
  input  logic [BYTE_W-1:0]               rxHead,
  output qStrobes_t                       stb,
  output logic                            txEmptyEvt,
  output logic                            rxFullEvt
);
  localparam int TX_LW = $clog2(TX_DEPTH + 1);
  localparam int RX_LW = $clog2(RX_DEPTH + 1);

  logic             cmdWr, cmdRd, evtWr;
  logic [TX_LW-1:0] txThr;
  logic [RX_LW-1:0] rxThr;
  logic             txOverF, rxUnderF, rxOverF;
  logic             unusedBits;

  assign unusedBits = ^regWrData[REG_DATA_W-1:CMD_W];

  assign cmdWr = regWrEn && (regAddr == ADDR_CMD);
  assign cmdRd = regRdEn && (regAddr == ADDR_CMD);
  assign evtWr = regWrEn && (regAddr == ADDR_EVT);

  // an overflowing entry is judged against the count at the start of the cycle
  always_comb begin
    stb.flush  = abortReq;
    stb.txPush = cmdWr    && !txIsFull  && !abortReq;
    stb.txPop  = txReady  && !txIsEmpty && !abortReq;
    stb.rxPush = rxStrobe && !rxIsFull  && !abortReq;
    stb.rxPop  = cmdRd    && !rxIsEmpty && !abortReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr <= '0;
      rxThr <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_TXTHR) txThr <= regWrData[TX_LW-1:0];
      if (regAddr == ADDR_RXTHR) rxThr <= regWrData[RX_LW-1:0];
    end
  end

  // sticky error flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOverF  <= 1'b0;
      rxUnderF <= 1'b0;
      rxOverF  <= 1'b0;
    end else begin
      txOverF  <= (cmdWr && txIsFull)     || (txOverF  && !(evtWr && regWrData[EVT_TXOVER]));
      rxUnderF <= (cmdRd && rxIsEmpty)    || (rxUnderF && !(evtWr && regWrData[EVT_RXUNDER]));
      rxOverF  <= (rxStrobe && rxIsFull)  || (rxOverF  && !(evtWr && regWrData[EVT_RXOVER]));
    end
  end

  assign txEmptyEvt = (txLevel <= txThr);
  assign rxFullEvt  = (rxLevel >  rxThr);

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CMD:   regRdData = rxIsEmpty ? '0 : REG_DATA_W'(rxHead);
      ADDR_TXLVL: regRdData = REG_DATA_W'(txLevel);
      ADDR_RXLVL: regRdData = REG_DATA_W'(rxLevel);
      ADDR_TXTHR: regRdData = REG_DATA_W'(txThr);
      ADDR_RXTHR: regRdData = REG_DATA_W'(rxThr);
      ADDR_EVT:   regRdData = REG_DATA_W'({rxFullEvt, txEmptyEvt, rxOverF, rxUnderF, txOverF});
      default:    regRdData = '0;
    endcase
  end

  AST_TXOVER_RAISED:   assert property (@(posedge clk) disable iff (!rstN) (cmdWr && txIsFull) |=> txOverF);      // R8
  AST_RXUNDER_RAISED:  assert property (@(posedge clk) disable iff (!rstN) (cmdRd && rxIsEmpty) |=> rxUnderF);    // R9
  AST_RXOVER_RAISED:   assert property (@(posedge clk) disable iff (!rstN) (rxStrobe && rxIsFull) |=> rxOverF);   // R10
  AST_TXLOW_WHEN_DRY:  assert property (@(posedge clk) disable iff (!rstN) txIsEmpty |-> txEmptyEvt);             // R5
  AST_RXHIGH_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN) rxFullEvt |-> !rxIsEmpty);             // R6
endmodule

// File: rtl/i2c_xfer_queue.sv
module i2c_xfer_queue
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [2:0]            regAddr,
  input  logic [15:0]           regWrData,
  output logic [15:0]           regRdData,
  output logic                  txValid,
  input  logic                  txReady,
  output logic [8:0]            txCmd,
  input  logic                  rxStrobe,
  input  logic [7:0]            rxByte,
  input  logic                  abortReq,
  output logic                  txEmptyEvt,
  output logic                  rxFullEvt
);
  localparam int TX_LW = $clog2(TX_DEPTH + 1);
  localparam int RX_LW = $clog2(RX_DEPTH + 1);

  qStrobes_t          stb;
  logic [TX_LW-1:0]   txLevel;
  logic [RX_LW-1:0]   rxLevel;
  logic               txIsFull, txIsEmpty, rxIsFull, rxIsEmpty;
  logic [BYTE_W-1:0]  rxHead;

  i2cq_control #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txReady(txReady), .rxStrobe(rxStrobe), .abortReq(abortReq),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txIsFull(txIsFull), .txIsEmpty(txIsEmpty),
    .rxIsFull(rxIsFull), .rxIsEmpty(rxIsEmpty),
    .rxHead(rxHead), .stb(stb),
    .txEmptyEvt(txEmptyEvt), .rxFullEvt(rxFullEvt)
  );

  i2cq_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdWord(regWrData[CMD_W-1:0]), .rxDin(rxByte),
    .txHead(txCmd), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txIsFull(txIsFull), .txIsEmpty(txIsEmpty),
    .rxIsFull(rxIsFull), .rxIsEmpty(rxIsEmpty)
  );

  assign txValid = !txIsEmpty;

  AST_VALID_MEANS_DATA: assert property (@(posedge clk) disable iff (!rstN) (txValid && txReady && !abortReq) |=> (regAddr != 3'd1 || regRdData <= 16'(TX_DEPTH))); // R11
endmodule

// File: tb/tb_i2c_xfer_queue.sv
module tb_i2c_xfer_queue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        txValid, txReady = 1'b0;
  logic [8:0]  txCmd;
  logic        rxStrobe = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        abortReq = 1'b0;
  logic        txEmptyEvt, rxFullEvt;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  i2c_xfer_queue dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txValid(txValid), .txReady(txReady), .txCmd(txCmd),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .abortReq(abortReq),
    .txEmptyEvt(txEmptyEvt), .rxFullEvt(rxFullEvt)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output int v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 v = int'(regRdData);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rxPut(input logic [7:0] b);
    @(negedge clk);
    rxStrobe = 1'b1; rxByte = b;
    @(negedge clk);
    rxStrobe = 1'b0;
  endtask

  task automatic txTake(output int vld, output int cmd);
    @(negedge clk);
    vld = int'(txValid); cmd = int'(txCmd);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic testReset();
    int v;
    regRd(3'd1, v); check("R4", "tx level after reset", v, 0);
    regRd(3'd2, v); check("R4", "rx level after reset", v, 0);
    regRd(3'd5, v); check("R5", "event reg after reset", v, 'h8);
    check("R11", "txValid after reset", int'(txValid), 0);
  endtask

  task automatic testCmdQueue();
    int v, c;
    regWr(3'd0, 16'h00A5);
    regWr(3'd0, 16'h013C);
    regRd(3'd1, v); check("R4", "tx level two cmds", v, 2);
    txTake(v, c); check("R11", "valid with data", v, 1); check("R1", "data cmd", c, 'h0A5);
    txTake(v, c); check("R2", "read request word", c, 'h100);
    regRd(3'd1, v); check("R11", "tx level drained", v, 0);
    check("R11", "txValid drained", int'(txValid), 0);
  endtask

  task automatic testRxOrder();
    int v;
    rxPut(8'h11); rxPut(8'h22); rxPut(8'h33);
    regRd(3'd2, v); check("R4", "rx level three", v, 3);
    regRd(3'd0, v); check("R3", "first byte", v, 'h11);
    regRd(3'd0, v); check("R3", "second byte", v, 'h22);
    regRd(3'd0, v); check("R3", "third byte", v, 'h33);
    regRd(3'd2, v); check("R3", "rx level drained", v, 0);
  endtask

  task automatic testThresholds();
    int v, c;
    regWr(3'd3, 16'd2);
    regWr(3'd0, 16'h0001); regWr(3'd0, 16'h0002); regWr(3'd0, 16'h0003);
    #1 check("R5", "txEmptyEvt level 3 thr 2", int'(txEmptyEvt), 0);
    txTake(v, c);
    #1 check("R5", "txEmptyEvt level 2 thr 2", int'(txEmptyEvt), 1);
    regRd(3'd5, v); check("R5", "event bit3 at boundary", (v >> 3) & 1, 1);
    txTake(v, c); txTake(v, c);
    regWr(3'd4, 16'd1);
    rxPut(8'h40);
    #1 check("R6", "rxFullEvt level 1 thr 1", int'(rxFullEvt), 0);
    rxPut(8'h41);
    #1 check("R6", "rxFullEvt level 2 thr 1", int'(rxFullEvt), 1);
    regRd(3'd5, v); check("R6", "event bit4", (v >> 4) & 1, 1);
    regRd(3'd0, v); regRd(3'd0, v);
    regWr(3'd4, 16'd0);
  endtask

  task automatic testTxOverflow();
    int v, c;
    for (int i = 0; i < 8; i++) regWr(3'd0, 16'(8'h50 + i));
    regWr(3'd0, 16'h00FF);
    regRd(3'd1, v); check("R8", "tx level stays full", v, 8);
    regRd(3'd5, v); check("R8", "tx overflow flag", v & 1, 1);
    for (int i = 0; i < 8; i++) begin
      txTake(v, c); check("R8", "queued cmd intact", c, 'h50 + i);
    end
    regWr(3'd5, 16'h0000);
    regRd(3'd5, v); check("R12", "write 0 keeps flag", v & 1, 1);
    regWr(3'd5, 16'h0001);
    regRd(3'd5, v); check("R12", "write 1 clears flag", v & 1, 0);
  endtask

  task automatic testRxUnderflow();
    int v;
    regRd(3'd0, v); check("R9", "empty read data", v, 0);
    regRd(3'd2, v); check("R9", "rx level after empty read", v, 0);
    regRd(3'd5, v); check("R9", "rx underflow flag", (v >> 1) & 1, 1);
    regWr(3'd5, 16'h0002);
    regRd(3'd5, v); check("R12", "underflow cleared", (v >> 1) & 1, 0);
  endtask

  task automatic testRxOverflow();
    int v;
    for (int i = 0; i < 9; i++) rxPut(8'(8'hC0 + i));
    regRd(3'd2, v); check("R10", "rx level stays full", v, 8);
    regRd(3'd5, v); check("R10", "rx overflow flag", (v >> 2) & 1, 1);
    for (int i = 0; i < 8; i++) begin
      regRd(3'd0, v); check("R10", "kept byte", v, 'hC0 + i);
    end
    regWr(3'd5, 16'h0004);
    regRd(3'd5, v); check("R12", "rx overflow cleared", (v >> 2) & 1, 0);
  endtask

  task automatic testAbort();
    int v;
    regWr(3'd0, 16'h0011); regWr(3'd0, 16'h0022); regWr(3'd0, 16'h0100);
    rxPut(8'h77); rxPut(8'h78);
    @(negedge clk); abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    regRd(3'd1, v); check("R7", "tx level after abort", v, 0);
    regRd(3'd2, v); check("R7", "rx level after abort", v, 0);
    check("R7", "txValid after abort", int'(txValid), 0);
    regWr(3'd0, 16'h0099);
    #1 check("R7", "queue usable after abort", int'(txCmd), 'h099);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCmdQueue();
    testRxOrder();
    testThresholds();
    testTxOverflow();
    testRxUnderflow();
    testRxOverflow();
    testAbort();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule